// File: doc/BRIEF.md
# Expansion Backplane Collision and Arbitration Controller

This block is the glue logic of one buffered expansion backplane on a 68000-style bus. During every bus cycle it counts how many responders claim the cycle. The responders are the cards in the local slots, which pull their slave-claim lines low. They also include everything further out along the chain, which is reported on a single upstream claim line. The host's own memory map counts as a responder too, and is decoded from the five top address bits. When two or more of them answer at once, the block pulls bus error low and keeps it low until the address strobe is released. While bus error is active, the block holds the backplane data drivers off.

The drivers turn on only after a delayed address strobe. The block derives that strobe by counting rising edges of the processor-rate clock, which it rebuilds from two of the host's phase clocks. Because of this delay, any collision is seen and flagged before a driver can drive. The driver direction follows from the side the bus master sits on and from the read/write line.

Card bus requests are captured only on rising edges of the rebuilt processor clock. The captured requests feed a fixed-priority selection of one slot. The selected slot keeps its grant while it is still requesting or while bus-grant-acknowledge is held.

Top module: `bpx_backplane`

## Requirements
- R1: While `as_n` is low, each of these is one claim: a low bit of `slave_n`, a low `slave_up_n`, and an `addr_hi` value inside either internal window (by default 0 to 3 and 24 to 31, both inclusive). Two or more claims make a collision. While `as_n` is high there are no claims.
- R2: `berr_n` goes low on the clock edge after a collision is first sampled. It stays low while `as_n` stays low, even if the claims drop away. It returns high on the edge after `as_n` is sampled high.
- R3: A cycle that never has more than one claim leaves `berr_n` high.
- R4: The processor clock is `c1` XNOR `c3_n`. A rising edge is a clock sample where this value is high after a low sample. The delayed strobe becomes active once S4_TICKS such edges have been counted while `as_n` is low, and the count clears whenever `as_n` is sampled high. `drv_en` stays low before the delayed strobe.
- R5: `drv_en` is high only when all of these hold: the delayed strobe is active, no bus error is latched, no collision is present in the current cycle, and there is exactly one claim. That claim must also sit on the far side from the master. With the host as master the claim must come from a card (local slot or upstream). With a local card as master the claim must be the internal window.
- R6: `drv_dir_up` = 1 drives toward the cards. With the host as master it is 1 on a write (`rw` = 0) and 0 on a read (`rw` = 1). With a local card as master the two cases swap.
- R7: `breq_sync[i]` takes the value of the inverted `breq_n[i]` only on processor-clock rising edges and holds between them. A request pulse that begins and ends between two edges is never seen.
- R8: When no slot holds the grant, each processor-clock rising edge grants the lowest-numbered slot whose synchronised request was already set. Slot 0 has the highest priority. `grant` is one-hot or zero.
- R9: A granted slot keeps `grant` while its synchronised request is set or while `bgack_n` is low. The grant is dropped at the first processor-clock rising edge where both have ended. A local card counts as master while it holds the grant and `bgack_n` is low.
- R10: During and just after reset, `berr_n` = 1, `drv_en` = 0, `breq_sync` = 0 and `grant` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of the glue logic |
| rst | input | 1 | Synchronous reset, active high |
| c1 | input | 1 | Host phase clock one |
| c3_n | input | 1 | Host phase clock three, inverted |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr_hi | input | 5 | Address bits 23 down to 19 |
| slave_n | input | NUM_SLOTS | Per-slot claim lines, active low |
| slave_up_n | input | 1 | Aggregate claim from the next backplane out, active low |
| breq_n | input | NUM_SLOTS | Per-slot bus requests, active low |
| bgack_n | input | 1 | Bus grant acknowledge, active low |
| berr_n | output | 1 | Bus error, active low (open-drain pull-down) |
| drv_en | output | 1 | Data driver enable |
| drv_dir_up | output | 1 | Driver direction, 1 = toward the cards |
| breq_sync | output | NUM_SLOTS | Synchronised requests, active high |
| grant | output | NUM_SLOTS | One-hot slot grant |

## Verification
The bench builds the block with three slots and a delayed-strobe count of two processor-clock edges. With three slots, every pairing of local, upstream and internal claims can be set up in a handful of cycles. With the short count, the driver turns on early enough that a collision arriving after turn-on can be staged, which checks that the driver is cut in the same cycle. The default internal windows are kept, so both window edges and card space lie at addresses the bench uses directly. Requests are pulsed against the known phase of the rebuilt processor clock, which makes the between-edge case reachable on purpose.

// File: rtl/bpx_pkg.sv
package bpx_pkg;

    // Width of the upper address slice watched for the host's own map.
    localparam int ADDR_HI_W = 5;

    typedef enum logic {
        MASTER_HOST = 1'b0,
        MASTER_CARD = 1'b1
    } master_e;

    typedef struct packed {
        logic internal;   // host address map claims the cycle
        logic single;     // exactly one claim
        logic multi;      // two or more claims
    } claim_s;

    function automatic logic in_window(int a, int lo, int hi);
        return (a >= lo) && (a <= hi);
    endfunction

    // The claim must sit on the far side of the buffers from the master.
    function automatic logic crosses_buffers(master_e m, claim_s c);
        return (m == MASTER_CARD) ? c.internal : !c.internal;
    endfunction

    // 1 = data flows toward the cards.
    function automatic logic toward_cards(master_e m, logic rw);
        return (m == MASTER_CARD) ? rw : !rw;
    endfunction

endpackage

// File: rtl/bpx_clkgen.sv
module bpx_clkgen #(
    parameter int S4_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic c1,
    input  logic c3_n,
    input  logic as_n,
    output logic tick,
    output logic as_dly
);
    localparam int CW = $clog2(S4_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(S4_TICKS);

    logic          pclk;
    logic          pclk_q;
    logic [CW-1:0] cnt_q;

    assign pclk = ~(c1 ^ c3_n);
    assign tick = pclk & ~pclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            pclk_q <= pclk;
            if (as_n)
                cnt_q <= '0;
            else if (tick && cnt_q != LIMIT)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign as_dly = (cnt_q == LIMIT);

    // R4: a released strobe clears the delayed strobe on the next edge
    p_dly_clear_r4: assert property (@(posedge clk) disable iff (rst)
        as_n |=> !as_dly);

    // R4: the delayed strobe only appears right after a processor-clock edge
    p_dly_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(as_dly) |-> $past(tick));

endmodule

// File: rtl/bpx_collide.sv
module bpx_collide
    import bpx_pkg::*;
#(
    parameter int NUM_SLOTS = 5,
    parameter int WIN0_LO   = 0,
    parameter int WIN0_HI   = 3,
    parameter int WIN1_LO   = 24,
    parameter int WIN1_HI   = 31
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 as_n,
    input  logic [ADDR_HI_W-1:0] addr_hi,
    input  logic [NUM_SLOTS-1:0] slave_n,
    input  logic                 slave_up_n,
    output claim_s               claim,
    output logic                 berr_q
);
    localparam int CW = $clog2(NUM_SLOTS + 3);

    logic [NUM_SLOTS-1:0] slot_claim;
    logic                 up_claim;
    logic                 int_claim;
    logic [CW-1:0]        total;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_claim[g] = ~as_n & ~slave_n[g];
    end

    assign up_claim  = ~as_n & ~slave_up_n;
    assign int_claim = ~as_n & (in_window(int'(addr_hi), WIN0_LO, WIN0_HI) |
                                in_window(int'(addr_hi), WIN1_LO, WIN1_HI));

    always_comb begin
        total = CW'(up_claim) + CW'(int_claim);
        for (int i = 0; i < NUM_SLOTS; i++)
            total = total + CW'(slot_claim[i]);
    end

    always_comb begin
        claim.internal = int_claim;
        claim.single   = (total == CW'(1));
        claim.multi    = (total >= CW'(2));
    end

    // Latched until the strobe goes away.
    always_ff @(posedge clk) begin
        if (rst)
            berr_q <= 1'b0;
        else
            berr_q <= ~as_n & (berr_q | claim.multi);
    end

    // R1: a collision always raises the bus error on the next edge
    p_raise_r1: assert property (@(posedge clk) disable iff (rst)
        claim.multi |=> berr_q);

    // R2: once raised, the error holds while the strobe is low
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (berr_q && !as_n) |=> berr_q);

    // R2: a released strobe clears the error
    p_release_r2: assert property (@(posedge clk) disable iff (rst)
        as_n |=> !berr_q);

    // R3: without a collision no error appears
    p_single_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!berr_q && !claim.multi) |=> !berr_q);

endmodule

// File: rtl/bpx_arbiter.sv
module bpx_arbiter
    import bpx_pkg::*;
#(
    parameter int NUM_SLOTS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [NUM_SLOTS-1:0] breq_n,
    input  logic                 bgack_n,
    output logic [NUM_SLOTS-1:0] breq_sync_q,
    output logic [NUM_SLOTS-1:0] grant_q,
    output master_e              master
);
    logic [NUM_SLOTS-1:0] pick;
    logic                 keep;

    always_comb begin
        pick = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (breq_sync_q[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    assign keep = (|(breq_sync_q & grant_q)) | ~bgack_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            breq_sync_q <= '0;
            grant_q     <= '0;
        end else if (tick) begin
            breq_sync_q <= ~breq_n;
            if (grant_q == '0)
                grant_q <= pick;
            else if (!keep)
                grant_q <= '0;
        end
    end

    assign master = ((|grant_q) && !bgack_n) ? MASTER_CARD : MASTER_HOST;

    // R8: never more than one slot granted
    p_grant_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q));

    // R7: the synchronised requests move only on processor-clock edges
    p_sync_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(breq_sync_q));

    // R9: an acknowledged grant cannot be lost or moved
    p_grant_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ((|grant_q) && !bgack_n) |=> (grant_q == $past(grant_q)));

endmodule

// File: rtl/bpx_steer.sv
module bpx_steer
    import bpx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    as_dly,
    input  logic    berr_q,
    input  claim_s  claim,
    input  master_e master,
    input  logic    rw,
    output logic    drv_en,
    output logic    drv_dir_up
);
    assign drv_en     = as_dly & ~berr_q & ~claim.multi & claim.single &
                        crosses_buffers(master, claim);
    assign drv_dir_up = toward_cards(master, rw);

    // R5: drivers stay off whenever the latched error is present
    p_quiet_in_error_r5: assert property (@(posedge clk) disable iff (rst)
        berr_q |-> !drv_en);

endmodule

// File: rtl/bpx_backplane.sv
module bpx_backplane
    import bpx_pkg::*;
#(
    parameter int NUM_SLOTS = 5,
    parameter int S4_TICKS  = 2,
    parameter int WIN0_LO   = 0,
    parameter int WIN0_HI   = 3,
    parameter int WIN1_LO   = 24,
    parameter int WIN1_HI   = 31
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 c1,
    input  logic                 c3_n,
    input  logic                 as_n,
    input  logic                 rw,
    input  logic [4:0]           addr_hi,
    input  logic [NUM_SLOTS-1:0] slave_n,
    input  logic                 slave_up_n,
    input  logic [NUM_SLOTS-1:0] breq_n,
    input  logic                 bgack_n,
    output logic                 berr_n,
    output logic                 drv_en,
    output logic                 drv_dir_up,
    output logic [NUM_SLOTS-1:0] breq_sync,
    output logic [NUM_SLOTS-1:0] grant
);
    logic    tick;
    logic    as_dly;
    claim_s  claim;
    logic    berr_q;
    master_e master;

    bpx_clkgen #(.S4_TICKS(S4_TICKS)) u_clk (
        .clk    (clk),
        .rst    (rst),
        .c1     (c1),
        .c3_n   (c3_n),
        .as_n   (as_n),
        .tick   (tick),
        .as_dly (as_dly)
    );

    bpx_collide #(
        .NUM_SLOTS (NUM_SLOTS),
        .WIN0_LO   (WIN0_LO),
        .WIN0_HI   (WIN0_HI),
        .WIN1_LO   (WIN1_LO),
        .WIN1_HI   (WIN1_HI)
    ) u_coll (
        .clk        (clk),
        .rst        (rst),
        .as_n       (as_n),
        .addr_hi    (addr_hi),
        .slave_n    (slave_n),
        .slave_up_n (slave_up_n),
        .claim      (claim),
        .berr_q     (berr_q)
    );

    bpx_arbiter #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .breq_n      (breq_n),
        .bgack_n     (bgack_n),
        .breq_sync_q (breq_sync),
        .grant_q     (grant),
        .master      (master)
    );

    bpx_steer u_steer (
        .clk        (clk),
        .rst        (rst),
        .as_dly     (as_dly),
        .berr_q     (berr_q),
        .claim      (claim),
        .master     (master),
        .rw         (rw),
        .drv_en     (drv_en),
        .drv_dir_up (drv_dir_up)
    );

    assign berr_n = ~berr_q;

endmodule

// File: tb/bpx_backplane_test.sv
`timescale 1ns/1ps
module bpx_backplane_test;
    localparam int NS = 3;
    localparam int S4 = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] phase = 2'd0;
    logic c1, c3_n;
    logic as_n = 1'b1, rw = 1'b1, slave_up_n = 1'b1, bgack_n = 1'b1;
    logic [4:0] addr_hi = 5'd8;
    logic [NS-1:0] slave_n = '1, breq_n = '1;
    logic berr_n, drv_en, drv_dir_up;
    logic [NS-1:0] breq_sync, grant;

    int compared = 0, mismatched = 0;
    bit armed = 0;

    // reference state
    bit m_prev, m_berr;
    int m_cnt;
    logic [NS-1:0] m_sync, m_grant;

    assign c1   = phase[1];
    assign c3_n = ~(phase[1] ^ phase[0]);

    bpx_backplane #(.NUM_SLOTS(NS), .S4_TICKS(S4)) uut (
        .clk(clk), .rst(rst), .c1(c1), .c3_n(c3_n), .as_n(as_n), .rw(rw),
        .addr_hi(addr_hi), .slave_n(slave_n), .slave_up_n(slave_up_n),
        .breq_n(breq_n), .bgack_n(bgack_n), .berr_n(berr_n), .drv_en(drv_en),
        .drv_dir_up(drv_dir_up), .breq_sync(breq_sync), .grant(grant));

    initial forever #2 clk = ~clk;
    initial forever begin @(negedge clk); phase = phase + 2'd1; end

    function automatic bit host_map(logic [4:0] a);
        return (a <= 5'd3) || (a >= 5'd24);
    endfunction

    function automatic int n_claims();
        int n = 0;
        if (!as_n) begin
            for (int i = 0; i < NS; i++) if (!slave_n[i]) n++;
            if (!slave_up_n) n++;
            if (host_map(addr_hi)) n++;
        end
        return n;
    endfunction

    // behavioural reference, advanced on every edge
    initial forever begin
        @(posedge clk);
        if (rst) begin
            m_prev = 0; m_cnt = 0; m_berr = 0; m_sync = '0; m_grant = '0;
        end else begin
            bit pnow, edge_seen;
            logic [NS-1:0] old_sync;
            pnow = (c1 ~^ c3_n);
            edge_seen = pnow && !m_prev;
            if (as_n) m_cnt = 0;
            else if (edge_seen && m_cnt < S4) m_cnt++;
            m_berr = !as_n && (m_berr || n_claims() >= 2);
            if (edge_seen) begin
                old_sync = m_sync;
                m_sync = ~breq_n;
                if (m_grant == '0) begin
                    for (int i = NS - 1; i >= 0; i--)
                        if (old_sync[i]) begin m_grant = '0; m_grant[i] = 1'b1; end
                end else if ((old_sync & m_grant) == '0 && bgack_n) begin
                    m_grant = '0;
                end
            end
            m_prev = pnow;
        end
    end

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string what);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    initial forever begin
        @(negedge clk); #1;
        if (armed) begin
            bit ml, intc, en;
            int n;
            n    = n_claims();
            ml   = (m_grant != '0) && !bgack_n;
            intc = !as_n && host_map(addr_hi);
            en   = (m_cnt == S4) && !m_berr && n == 1 && (ml ? intc : !intc);
            chk(8'(berr_n), 8'(!m_berr), "R2 berr_n vs model");
            chk(8'(drv_en), 8'(en), "R5 drv_en vs model");
            chk(8'(drv_dir_up), 8'(ml ? rw : !rw), "R6 drv_dir_up vs model");
            chk(8'(breq_sync), 8'(m_sync), "R7 breq_sync vs model");
            chk(8'(grant), 8'(m_grant), "R8 grant vs model");
        end
    end

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_idle();
        as_n = 1'b1; slave_n = '1; slave_up_n = 1'b1; addr_hi = 5'd8; rw = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #200000;
        mismatched++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        waitn(4);
        rst = 1'b0;
        armed = 1;
        #1;
        chk(8'(berr_n), 8'd1, "R10 berr_n after reset");
        chk(8'(drv_en), 8'd0, "R10 drv_en after reset");
        chk(8'(grant), 8'd0, "R10 grant after reset");
        chk(8'(breq_sync), 8'd0, "R10 breq_sync after reset");

        // host read of slot 1
        waitn(2);
        as_n = 1'b0; rw = 1'b1; addr_hi = 5'd8; slave_n = 3'b101;
        #1; chk(8'(drv_en), 8'd0, "R4 no drive before delayed strobe");
        waitn(8); #1;
        chk(8'(drv_en), 8'd1, "R5 single card claim drives");
        chk(8'(drv_dir_up), 8'd0, "R6 host read flows to host");
        chk(8'(berr_n), 8'd1, "R3 single claim no error");
        waitn(1); bus_idle(); waitn(3);

        // host write of slot 0
        as_n = 1'b0; rw = 1'b0; slave_n = 3'b110;
        waitn(8); #1;
        chk(8'(drv_dir_up), 8'd1, "R6 host write flows to cards");
        chk(8'(drv_en), 8'd1, "R5 write drive");
        waitn(1); bus_idle(); waitn(3);

        // two local slots collide, then one withdraws
        as_n = 1'b0; slave_n = 3'b010;
        waitn(3); #1;
        chk(8'(berr_n), 8'd0, "R1 two slots collide");
        waitn(1); slave_n = 3'b110;
        waitn(6); #1;
        chk(8'(berr_n), 8'd0, "R2 error latched after claim drops");
        chk(8'(drv_en), 8'd0, "R5 no drive while error latched");
        waitn(1); bus_idle(); waitn(2); #1;
        chk(8'(berr_n), 8'd1, "R2 error released with strobe");

        // slot plus upstream
        waitn(1); as_n = 1'b0; slave_n = 3'b011; slave_up_n = 1'b0;
        waitn(3); #1;
        chk(8'(berr_n), 8'd0, "R1 slot and upstream collide");
        waitn(1); bus_idle(); waitn(3);

        // slot plus internal window
        as_n = 1'b0; slave_n = 3'b101; addr_hi = 5'd2;
        waitn(3); #1;
        chk(8'(berr_n), 8'd0, "R1 slot and internal window collide");
        waitn(1); bus_idle(); waitn(3);

        // internal only with host master: same side, no drive
        as_n = 1'b0; addr_hi = 5'd24;
        waitn(8); #1;
        chk(8'(drv_en), 8'd0, "R5 host to internal not driven");
        chk(8'(berr_n), 8'd1, "R3 internal alone no error");
        waitn(1); bus_idle(); waitn(3);

        // upstream only
        as_n = 1'b0; slave_up_n = 1'b0;
        waitn(8); #1;
        chk(8'(drv_en), 8'd1, "R5 upstream claim driven");
        waitn(1); bus_idle(); waitn(3);

        // late collision after turn-on
        as_n = 1'b0; slave_n = 3'b101;
        waitn(8);
        slave_up_n = 1'b0;
        #1; chk(8'(drv_en), 8'd0, "R5 late collision cuts drive same cycle");
        waitn(2); #1;
        chk(8'(berr_n), 8'd0, "R1 late collision error");
        waitn(1); bus_idle(); waitn(3);

        // request pulse between processor-clock edges
        do begin @(negedge clk); #1; end while ((c1 ~^ c3_n) == 1'b1);
        breq_n[2] = 1'b0;
        @(negedge clk); breq_n[2] = 1'b1;
        #1; chk(8'(breq_sync), 8'd0, "R7 between-edge pulse ignored");
        waitn(3); #1;
        chk(8'(breq_sync), 8'd0, "R7 pulse still unseen");
        chk(8'(grant), 8'd0, "R8 no grant from unseen pulse");

        // slots 1 and 2 request
        waitn(1); breq_n = 3'b001;
        waitn(6); #1;
        chk(8'(breq_sync), 8'b110, "R7 requests captured");
        chk(8'(grant), 8'b010, "R8 lowest requesting slot wins");
        waitn(1); bgack_n = 1'b0; breq_n = 3'b111;
        waitn(6); #1;
        chk(8'(grant), 8'b010, "R9 grant held by acknowledge");

        // local card master reads host memory
        waitn(1); as_n = 1'b0; rw = 1'b1; addr_hi = 5'd2;
        waitn(8); #1;
        chk(8'(drv_en), 8'd1, "R5 card master to internal driven");
        chk(8'(drv_dir_up), 8'd1, "R6 card master read flows to cards");
        waitn(1); bus_idle(); bgack_n = 1'b1;
        waitn(6); #1;
        chk(8'(grant), 8'd0, "R9 grant dropped");

        // all slots request: slot 0 first
        waitn(1); breq_n = 3'b000;
        waitn(6); #1;
        chk(8'(grant), 8'b001, "R8 slot 0 has top priority");

        waitn(2);
        summary();
        $finish;
    end
endmodule